// File: doc/BRIEF.md
# Lockable Control Register File

This block is the register file that sits behind an 8-bit address, 8-bit data processor port. It receives a simple synchronous access: a write strobe or a read strobe, an address and write data, all sampled on the rising clock edge. The block holds a small set of configuration registers, an alarm status register with its mask, and two banks of receive-port registers. Read data appears one cycle after the read strobe and then holds until the next read.

Configuration registers are protected by a software key. Two writes in a row are needed to open them and two to close them again. The lock guards only the configuration registers. It never blocks reads, and it never blocks writes to the alarm registers or to the port banks. Each port bank has a power-down bit in the first configuration register. While that bit is set, the bank keeps its contents and drops every write. A read of the bank then returns the last value read from that bank.

Alarm sources arrive as one-cycle pulses and set sticky status bits. Software clears a status bit by writing 1 to it. A mask register selects which pending bits drive the interrupt output. That output is an open-drain pull enable: 1 means the line is pulled low.

Top module: `cfgreg_top`

## Requirements
- R1: After reset the block is locked, all configuration registers read 0x00, the alarm status reads 0x00, the mask (address 0x09) reads 0xFF, `irq_pull` is 0 and `rdata` is 0x00.
- R2: A write of 0x00 to address 0x00 followed, as the very next write, by 0xFF to address 0x01 unlocks the block. Configuration writes to addresses 0x02..0x07 then take effect.
- R3: A write of 0xDE to address 0x00 followed, as the very next write, by 0xAD to address 0x01 locks the block. While it is locked, writes to 0x02..0x07 leave those registers unchanged.
- R4: A key sequence is abandoned if any other write comes between its two writes, or if the second write carries data that does not match. The lock state then stays as it was. Reads between the two writes do not break the sequence.
- R5: The lock state never affects reads, and it never affects writes to the status register (0x08), the mask register (0x09) or the port banks.
- R6: Bit 0 of address 0x02 powers down port A (0x20..0x45) and bit 1 powers down port B (0x60..0x85). While a port is powered down, writes to its range are ignored and its contents are kept.
- R7: A read of a powered-down port's range returns the last value read from that port's range while it was powered up (0x00 if there has been no such read).
- R8: Alarm status bits at 0x08 are set by pulses on `alarm_evt` and stay set until software writes 1 to them. If a pulse and a clear hit the same bit in the same cycle, the bit stays set.
- R9: `irq_pull` is 1 exactly when some status bit is set and the matching bit of the mask at 0x09 is 0 (a mask bit of 1 blocks that source). It follows the registers with no extra delay.
- R10: The read result appears on `rdata` in the cycle after `rd_en` and holds until the next read. Unmapped addresses, including 0x00 and 0x01, read as 0x00, and writes to unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| alarm_evt | input | 8 | One-cycle alarm event pulses, one bit per source |
| rdata | output | 8 | Registered read data |
| irq_pull | output | 1 | Interrupt pull-low enable, 1 = line asserted |

## Verification
A write or an alarm pulse sampled at one rising edge changes the register state at that edge. So `irq_pull` is due at the following falling edge, and a write takes effect for any access in the next cycle. A read sampled at one edge shows its value on `rdata` at that same edge, and the bench samples it at the next falling edge. The behavioural model in the bench advances at every rising edge from the same inputs. At every falling edge the bench compares `rdata` and `irq_pull` with the model. Directed reads also check the expected values for each requirement.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;

  // Key sequence addresses and data codes
  localparam int KEY_ADDR_FIRST  = 'h00;
  localparam int KEY_ADDR_SECOND = 'h01;
  localparam int OPEN_CODE_A     = 'h00;
  localparam int OPEN_CODE_B     = 'hFF;
  localparam int SHUT_CODE_A     = 'hDE;
  localparam int SHUT_CODE_B     = 'hAD;

  // Alarm registers
  localparam int ALM_STAT_ADDR   = 'h08;
  localparam int ALM_MASK_ADDR   = 'h09;

  typedef enum logic [1:0] {
    KEY_IDLE  = 2'd0,
    KEY_OPEN  = 2'd1,
    KEY_SHUT  = 2'd2
  } key_state_t;

  // True when address a lies in [base, base+count)
  function automatic logic in_window(input int a, input int base, input int count);
    return (a >= base) && (a < base + count);
  endfunction

  // Next key-tracker state after a write to the first key address
  function automatic key_state_t arm_from(input int data);
    if (data == OPEN_CODE_A) return KEY_OPEN;
    if (data == SHUT_CODE_A) return KEY_SHUT;
    return KEY_IDLE;
  endfunction

endpackage

// File: rtl/cfgreg_lockseq.sv
module cfgreg_lockseq
  import cfgreg_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          locked
);

  key_state_t key_q;
  logic       second_hit;
  logic       open_fire;
  logic       shut_fire;

  assign second_hit = wr_en && (int'(addr) == KEY_ADDR_SECOND);
  assign open_fire  = second_hit && (key_q == KEY_OPEN) && (int'(wdata) == OPEN_CODE_B);
  assign shut_fire  = second_hit && (key_q == KEY_SHUT) && (int'(wdata) == SHUT_CODE_B);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_q  <= KEY_IDLE;
      locked <= 1'b1;
    end else if (wr_en) begin
      if (open_fire) locked <= 1'b0;
      else if (shut_fire) locked <= 1'b1;
      if (int'(addr) == KEY_ADDR_FIRST) key_q <= arm_from(int'(wdata));
      else key_q <= KEY_IDLE;
    end
  end

endmodule

// File: rtl/cfgreg_portbank.sv
module cfgreg_portbank
  import cfgreg_pkg::*;
#(
  parameter int AW   = 8,
  parameter int DW   = 8,
  parameter int BASE = 'h20,
  parameter int NREG = 38
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pdn,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      wdata,
  output logic               hit,
  output logic [DW-1:0]      rd_val,
  output logic [NREG*DW-1:0] image
);

  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

  logic [NREG-1:0][DW-1:0] mem_q;
  logic [DW-1:0]           last_q;
  logic [IW-1:0]           idx;
  logic [DW-1:0]           live_val;
  logic                    wr_ok;

  assign hit      = in_window(int'(addr), BASE, NREG);
  assign idx      = IW'(addr - AW'(BASE));
  assign live_val = hit ? mem_q[idx] : '0;
  assign wr_ok    = wr_en && hit && !pdn;
  assign rd_val   = pdn ? last_q : live_val;
  assign image    = mem_q;

  for (genvar g = 0; g < NREG; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rst_n) mem_q[g] <= '0;
      else if (wr_ok && (idx == IW'(g))) mem_q[g] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= '0;
    else if (rd_en && hit && !pdn) last_q <= live_val;
  end

endmodule

// File: rtl/cfgreg_alarm.sv
module cfgreg_alarm #(
  parameter int DW     = 8,
  parameter int NALARM = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NALARM-1:0] evt,
  input  logic              clr_we,
  input  logic              mask_we,
  input  logic [DW-1:0]     wdata,
  output logic [NALARM-1:0] status,
  output logic [NALARM-1:0] mask,
  output logic              irq_pull
);

  function automatic logic pending_any(input logic [NALARM-1:0] st, input logic [NALARM-1:0] mk);
    return |(st & ~mk);
  endfunction

  logic [NALARM-1:0] clr_bits;
  assign clr_bits = clr_we ? wdata[NALARM-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      mask   <= '1;
    end else begin
      status <= (status & ~clr_bits) | evt;
      if (mask_we) mask <= wdata[NALARM-1:0];
    end
  end

  assign irq_pull = pending_any(status, mask);

endmodule

// File: rtl/cfgreg_top.sv
module cfgreg_top
  import cfgreg_pkg::*;
#(
  parameter int AW         = 8,
  parameter int DW         = 8,
  parameter int NALARM     = 8,
  parameter int CFG_BASE   = 'h02,
  parameter int NCFG       = 6,
  parameter int PORTA_BASE = 'h20,
  parameter int PORTB_BASE = 'h60,
  parameter int PORT_NREG  = 38
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  input  logic [NALARM-1:0] alarm_evt,
  output logic [DW-1:0]     rdata,
  output logic              irq_pull
);

  localparam int CIW    = (NCFG > 1) ? $clog2(NCFG) : 1;
  localparam int NBANK  = 2;

  // Lock tracker
  logic locked;

  cfgreg_lockseq #(.AW(AW), .DW(DW)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .locked (locked)
  );

  // Configuration registers
  logic [NCFG-1:0][DW-1:0] cfg_q;
  logic                    cfg_hit;
  logic [CIW-1:0]          cfg_idx;
  logic                    cfg_we;

  assign cfg_hit = in_window(int'(addr), CFG_BASE, NCFG);
  assign cfg_idx = CIW'(addr - AW'(CFG_BASE));
  assign cfg_we  = wr_en && cfg_hit && !locked;

  for (genvar g = 0; g < NCFG; g++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (!rst_n) cfg_q[g] <= '0;
      else if (cfg_we && (cfg_idx == CIW'(g))) cfg_q[g] <= wdata;
    end
  end

  // Power-down controls live in the first configuration register
  logic [NBANK-1:0] pdn_vec;
  assign pdn_vec = cfg_q[0][NBANK-1:0];

  // Receive-port banks
  logic [NBANK-1:0]                   bank_hit;
  logic [NBANK-1:0][DW-1:0]           bank_val;
  logic [NBANK-1:0][PORT_NREG*DW-1:0] bank_img;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    cfgreg_portbank #(
      .AW   (AW),
      .DW   (DW),
      .BASE ((b == 0) ? PORTA_BASE : PORTB_BASE),
      .NREG (PORT_NREG)
    ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .pdn    (pdn_vec[b]),
      .wr_en  (wr_en),
      .rd_en  (rd_en),
      .addr   (addr),
      .wdata  (wdata),
      .hit    (bank_hit[b]),
      .rd_val (bank_val[b]),
      .image  (bank_img[b])
    );
  end

  // Alarm status and mask
  logic              stat_sel;
  logic              mask_sel;
  logic [NALARM-1:0] alarm_status;
  logic [NALARM-1:0] mask_q;

  assign stat_sel = (int'(addr) == ALM_STAT_ADDR);
  assign mask_sel = (int'(addr) == ALM_MASK_ADDR);

  cfgreg_alarm #(.DW(DW), .NALARM(NALARM)) u_alarm (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (alarm_evt),
    .clr_we   (wr_en && stat_sel),
    .mask_we  (wr_en && mask_sel),
    .wdata    (wdata),
    .status   (alarm_status),
    .mask     (mask_q),
    .irq_pull (irq_pull)
  );

  // Read path
  logic          unmapped;
  logic [DW-1:0] rd_mux;

  assign unmapped = !(|bank_hit || cfg_hit || stat_sel || mask_sel);

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (bank_hit[b]) rd_mux = bank_val[b];
    end
    if (cfg_hit)  rd_mux = cfg_q[cfg_idx];
    if (stat_sel) rd_mux = DW'(alarm_status);
    if (mask_sel) rd_mux = DW'(mask_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

endmodule

// File: rtl/cfgreg_checker.sv
module cfgreg_checker
  import cfgreg_pkg::*;
#(
  parameter int AW     = 8,
  parameter int DW     = 8,
  parameter int NALARM = 8,
  parameter int NCFG   = 6,
  parameter int NREG   = 38
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        wr_en,
  input logic                        rd_en,
  input logic [AW-1:0]               addr,
  input logic [DW-1:0]               wdata,
  input logic [NALARM-1:0]           alarm_evt,
  input logic [DW-1:0]               rdata,
  input logic                        irq_pull,
  input logic                        locked,
  input logic [NCFG-1:0][DW-1:0]     cfg_q,
  input logic                        cfg_hit,
  input logic [1:0]                  pdn_vec,
  input logic [1:0]                  bank_hit,
  input logic [1:0][NREG*DW-1:0]     bank_img,
  input logic [NALARM-1:0]           alarm_status,
  input logic [NALARM-1:0]           mask_q,
  input logic                        unmapped
);

  // R2: a completed open sequence clears the lock
  p_open_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(addr) == KEY_ADDR_SECOND && int'(wdata) == OPEN_CODE_B &&
     $past(wr_en && int'(addr) == KEY_ADDR_FIRST && int'(wdata) == OPEN_CODE_A))
    |=> !locked);

  // R3: a completed close sequence sets the lock
  p_shut_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(addr) == KEY_ADDR_SECOND && int'(wdata) == SHUT_CODE_B &&
     $past(wr_en && int'(addr) == KEY_ADDR_FIRST && int'(wdata) == SHUT_CODE_A))
    |=> locked);

  // R3: configuration is frozen while locked
  p_cfg_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && wr_en && cfg_hit) |=> $stable(cfg_q));

  // R4: a second write with foreign data never moves the lock
  p_bad_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(addr) == KEY_ADDR_SECOND &&
     int'(wdata) != OPEN_CODE_B && int'(wdata) != SHUT_CODE_B) |=> $stable(locked));

  // R6: a powered-down bank keeps its contents
  p_pdn_drop_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && pdn_vec[0] && bank_hit[0]) |=> $stable(bank_img[0]));
  p_pdn_drop_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && pdn_vec[1] && bank_hit[1]) |=> $stable(bank_img[1]));

  // R7: back-to-back reads of a powered-down bank give the same value
  p_pdn_repeat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && bank_hit[0] && pdn_vec[0] && $past(rd_en && bank_hit[0] && pdn_vec[0]))
    |=> $stable(rdata));

  // R8: status bits only fall on a write to the status register
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && int'(addr) == ALM_STAT_ADDR) |=> ((alarm_status & $past(alarm_status)) == $past(alarm_status)));

  // R9: interrupt edges have a cause one cycle earlier
  p_irq_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pull) |-> ($past(|alarm_evt) || $past(wr_en && int'(addr) == ALM_MASK_ADDR)));
  p_irq_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_pull) |-> $past(wr_en && (int'(addr) == ALM_STAT_ADDR || int'(addr) == ALM_MASK_ADDR)));

  // R10: unmapped reads return zero; rdata only moves after a read
  p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && unmapped) |=> (rdata == '0));
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  // R10: unmapped writes leave state untouched
  p_unmapped_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && unmapped && int'(addr) != KEY_ADDR_FIRST && int'(addr) != KEY_ADDR_SECOND)
    |=> ($stable(cfg_q) && $stable(bank_img) && $stable(mask_q)));

endmodule

bind cfgreg_top cfgreg_checker #(
  .AW     (AW),
  .DW     (DW),
  .NALARM (NALARM),
  .NCFG   (NCFG),
  .NREG   (PORT_NREG)
) u_chk (.*);

// File: tb/sim_cfgreg_top.sv
`timescale 1ns/1ps
module sim_cfgreg_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] alarm_evt = '0;
  logic [7:0] rdata;
  logic       irq_pull;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 1'b0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  cfgreg_top u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .alarm_evt (alarm_evt),
    .rdata     (rdata),
    .irq_pull  (irq_pull)
  );

  // ---------------- behavioural reference model ----------------
  int  mm [256];
  int  last_rd [2];
  bit  m_locked;
  int  armed;          // 0 none, 1 open, 2 shut
  int  m_stat, m_mask;
  int  m_rdata;
  bit  m_irq;
  int  ma, mport, md;

  function automatic int port_of(input int a);
    if (a >= 'h20 && a <= 'h45) return 0;
    if (a >= 'h60 && a <= 'h85) return 1;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mm[i]) mm[i] = 0;
      last_rd[0] = 0; last_rd[1] = 0;
      m_locked = 1; armed = 0;
      m_stat = 0; m_mask = 255;
      m_rdata = 0; m_irq = 0;
    end else begin
      ma = int'(addr); md = int'(wdata); mport = port_of(ma);
      if (rd_en) begin
        if (mport >= 0) begin
          if (((mm[2] >> mport) & 1) != 0) m_rdata = last_rd[mport];
          else begin last_rd[mport] = mm[ma]; m_rdata = mm[ma]; end
        end else if (ma >= 2 && ma <= 7) m_rdata = mm[ma];
        else if (ma == 8) m_rdata = m_stat;
        else if (ma == 9) m_rdata = m_mask;
        else m_rdata = 0;
      end
      if (wr_en) begin
        if (ma == 1) begin
          if (armed == 1 && md == 'hFF) m_locked = 0;
          if (armed == 2 && md == 'hAD) m_locked = 1;
        end
        if (ma == 0) armed = (md == 0) ? 1 : ((md == 'hDE) ? 2 : 0);
        else armed = 0;
        if (ma >= 2 && ma <= 7 && !m_locked) mm[ma] = md;
        if (mport >= 0 && ((mm[2] >> mport) & 1) == 0) mm[ma] = md;
        if (ma == 8) m_stat = m_stat & ~md & 255;
        if (ma == 9) m_mask = md;
      end
      m_stat = m_stat | int'(alarm_evt);
      m_irq = (m_stat & ~m_mask & 255) != 0;
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_on && !finished) begin
      checks++;
      if (int'(rdata) != m_rdata) begin
        errors++;
        $display("FAIL R10 per-cycle rdata actual=%02h expected=%02h", rdata, m_rdata[7:0]);
      end
      checks++;
      if (irq_pull != m_irq) begin
        errors++;
        $display("FAIL R9 per-cycle irq_pull actual=%0b expected=%0b", irq_pull, m_irq);
      end
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
    #1;
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL %s read %02h actual=%02h expected=%02h", tag, a, rdata, exp);
    end
  endtask

  task automatic pulse(input logic [7:0] e);
    @(negedge clk); alarm_evt = e;
    @(negedge clk); alarm_evt = '0;
  endtask

  task automatic irq_chk(input logic exp, input string tag);
    #1;
    checks++;
    if (irq_pull !== exp) begin
      errors++;
      $display("FAIL %s irq_pull actual=%0b expected=%0b", tag, irq_pull, exp);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- directed sequence ----------------
  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    #1;
    checks++;
    if (rdata !== 8'h00) begin
      errors++;
      $display("FAIL R1 reset rdata actual=%02h expected=00", rdata);
    end
    irq_chk(1'b0, "R1");
    rd_chk(8'h02, 8'h00, "R1");
    rd_chk(8'h09, 8'hFF, "R1");
    rd_chk(8'h08, 8'h00, "R1");

    // Locked at reset
    wr(8'h03, 8'h5A);
    rd_chk(8'h03, 8'h00, "R3");

    // Open, with a read between the key writes
    wr(8'h00, 8'h00);
    rd_chk(8'h09, 8'hFF, "R4");
    wr(8'h01, 8'hFF);
    wr(8'h03, 8'h5A);
    rd_chk(8'h03, 8'h5A, "R2");

    // Close
    wr(8'h00, 8'hDE);
    wr(8'h01, 8'hAD);
    wr(8'h03, 8'h11);
    rd_chk(8'h03, 8'h5A, "R3");

    // Interrupted sequence; port write still lands while locked
    wr(8'h00, 8'h00);
    wr(8'h22, 8'h07);
    wr(8'h01, 8'hFF);
    wr(8'h03, 8'h22);
    rd_chk(8'h03, 8'h5A, "R4");
    rd_chk(8'h22, 8'h07, "R5");

    // Wrong second data, and mismatched pairing
    wr(8'h00, 8'h00);
    wr(8'h01, 8'hFE);
    wr(8'h03, 8'h23);
    rd_chk(8'h03, 8'h5A, "R4");
    wr(8'h00, 8'hDE);
    wr(8'h01, 8'hFF);
    wr(8'h03, 8'h24);
    rd_chk(8'h03, 8'h5A, "R4");

    // Mask writable while locked
    wr(8'h09, 8'hFA);
    rd_chk(8'h09, 8'hFA, "R5");

    // Alarms
    pulse(8'h01);
    irq_chk(1'b1, "R9");
    rd_chk(8'h08, 8'h01, "R8");
    pulse(8'h02);
    wr(8'h08, 8'h01);
    irq_chk(1'b0, "R9");
    rd_chk(8'h08, 8'h02, "R8");
    @(negedge clk); wr_en = 1'b1; addr = 8'h08; wdata = 8'h04; alarm_evt = 8'h04;
    @(negedge clk); wr_en = 1'b0; alarm_evt = '0;
    irq_chk(1'b1, "R8");
    rd_chk(8'h08, 8'h06, "R8");
    wr(8'h08, 8'hFF);
    irq_chk(1'b0, "R8");
    rd_chk(8'h08, 8'h00, "R8");
    wr(8'h09, 8'hFF);
    pulse(8'h01);
    irq_chk(1'b0, "R9");
    wr(8'h09, 8'hFE);
    irq_chk(1'b1, "R9");
    wr(8'h08, 8'h01);
    irq_chk(1'b0, "R9");

    // Power-down of the port banks
    wr(8'h00, 8'h00);
    wr(8'h01, 8'hFF);
    wr(8'h21, 8'h44);
    wr(8'h45, 8'hC3);
    wr(8'h85, 8'h3C);
    rd_chk(8'h21, 8'h44, "R6");
    wr(8'h02, 8'h01);
    wr(8'h21, 8'h99);
    rd_chk(8'h20, 8'h44, "R7");
    rd_chk(8'h45, 8'h44, "R7");
    rd_chk(8'h85, 8'h3C, "R6");
    wr(8'h85, 8'h5B);
    rd_chk(8'h85, 8'h5B, "R6");
    wr(8'h02, 8'h02);
    rd_chk(8'h21, 8'h44, "R6");
    wr(8'h60, 8'h11);
    rd_chk(8'h60, 8'h5B, "R7");
    wr(8'h02, 8'h00);
    rd_chk(8'h60, 8'h00, "R6");
    rd_chk(8'h45, 8'hC3, "R6");

    // Unmapped space
    wr(8'h46, 8'h77);
    rd_chk(8'h46, 8'h00, "R10");
    rd_chk(8'h00, 8'h00, "R10");
    rd_chk(8'h01, 8'h00, "R10");
    rd_chk(8'h86, 8'h00, "R10");
    repeat (3) @(negedge clk);
    #1;
    checks++;
    if (rdata !== 8'h00) begin
      errors++;
      $display("FAIL R10 hold rdata actual=%02h expected=00", rdata);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule